// File: doc/BRIEF.md
# Microinstruction Field Decoder and Accumulator Datapath

This block carries out one 20-bit microinstruction on each clock edge. It works on a small accumulator datapath. Three 3-bit operation fields are each decoded into a one-hot vector. Those vectors drive register load enables and multiplexer selects directly, so up to three microoperations take effect in the same cycle.

The datapath holds the following registers:
- a 16-bit accumulator (AC);
- a 16-bit data register (DR);
- an 11-bit address register (AR);
- an 11-bit program counter (PC).

It also holds a 2048 x 16 internal memory. The condition, branch and address fields of the word go straight through to a separate next-address sequencer and are not used here. That sequencer also reads the status outputs: AC sign, AC zero, DR[15], and DR[14:11], which is the opcode field of an instruction word whose layout is indirect flag, opcode, address.

Microinstructions arrive on a valid/ready input. `uop_ready` is held high: the block never applies back-pressure. Each cycle in which `uop_valid` is high consumes exactly one word. A cycle with `uop_valid` low performs no operation. A separate preload port writes the memory directly, for test setup.

Top module: `uop_exec`

## Requirements
- R1: The word is split, from MSB to LSB, into these fields: op field A [19:17], op field B [16:14], op field C [13:11], condition [10:9], branch [8:7], address [6:0]. The condition, branch and address fields appear unchanged and combinationally on `cd_out`, `br_out` and `ad_out`.
- R2: While `rst` is high at a rising edge, AC, DR, AR and PC are cleared to 0, and no microoperation is performed that cycle.
- R3: When `uop_valid` is low, or all three op fields are 000, no register and no memory word changes, apart from preload writes. `uop_ready` is always 1.
- R4: Field A codes that act on AC, with 16-bit wrap: 001 sets AC to AC+DR; 010 clears AC; 011 sets AC to AC+1; 100 copies DR to AC.
- R5: Field A = 101 loads AR from DR[10:0]. Field A = 110 loads AR from PC. Every other code leaves AR unchanged.
- R6: Field A = 111 writes DR into memory at AR. Field B = 100 loads DR from memory at AR. If a read and a write hit the same word in the same cycle, the read returns the contents from before that cycle.
- R7: Field B codes that act on AC: 001 sets AC to AC-DR; 010 sets AC to AC OR DR; 011 sets AC to AC AND DR. Field C codes that act on AC: 001 sets AC to AC XOR DR; 010 sets AC to NOT AC; 011 shifts AC left with zero fill; 100 shifts AC right with zero fill.
- R8: The AC results of the three fields chain in the order A, then B, then C. Each stage works on the result of the stage before it. All DR, AR and PC operands are the values held at the start of the cycle. For example, A=010 with B=001 gives 0-DR.
- R9: Field B codes that load DR, using start-of-cycle values: 101 copies AC to DR; 110 sets DR to DR+1; 111 loads DR[10:0] from PC and keeps DR[15:11].
- R10: Field C = 101 increments PC with 11-bit wrap. Field C = 110 loads PC from AR. Field C = 111, and every other code, leaves PC unchanged.
- R11: The status outputs follow the registers: `ac_sign` = AC[15]; `ac_zero` = (AC == 0); `dr_ind` = DR[15]; `dr_opc` = DR[14:11]. The views `ac_out`, `dr_out`, `ar_out` and `pc_out` show the four registers.
- R12: When `pre_we` is high, `pre_data` is written to memory at `pre_addr` on the clock edge. This happens independent of reset and valid. If a field-A 111 write targets the same word in the same cycle, the preload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uop_valid | input | 1 | Microinstruction present this cycle |
| uop_ready | output | 1 | Always 1; no back-pressure |
| uop_word | input | 20 | Microinstruction word |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 11 | Preload address |
| pre_data | input | 16 | Preload data |
| cd_out | output | 2 | Condition field, passed through |
| br_out | output | 2 | Branch field, passed through |
| ad_out | output | 7 | Address field, passed through |
| ac_sign | output | 1 | AC[15] |
| ac_zero | output | 1 | AC equals zero |
| dr_ind | output | 1 | DR[15], indirect flag |
| dr_opc | output | 4 | DR[14:11], opcode |
| ac_out | output | 16 | Accumulator view |
| dr_out | output | 16 | Data register view |
| ar_out | output | 11 | Address register view |
| pc_out | output | 11 | Program counter view |

## Verification
The assertions check the following properties on every cycle:
- an idle cycle leaves all four registers unchanged;
- AR takes DR[10:0] on its field-A code;
- PC increments or holds according to field C;
- DR takes the start-of-cycle AC on its field-B copy code.

Some behaviours only the bench's reference model can show:
- the A-B-C chaining of AC results;
- the arithmetic and shift results;
- read-before-write on a same-address memory access;
- preload taking priority over a microinstruction write;
- the reset values.

The bench checks these in random and directed sequences.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int UOP_W  = 20;
  localparam int FLD_W  = 3;
  localparam int NCODE  = 1 << FLD_W;
  localparam int FA_LSB = 17;
  localparam int FB_LSB = 14;
  localparam int FC_LSB = 11;
  localparam int CD_W   = 2;
  localparam int BR_W   = 2;
  localparam int AD_W   = 7;
  localparam int CD_LSB = 9;
  localparam int BR_LSB = 7;

  typedef enum logic [FLD_W-1:0] {
    A_NOP, A_ADD, A_CLR, A_INC, A_DR2AC, A_DR2AR, A_PC2AR, A_WRITE
  } fa_e;

  typedef enum logic [FLD_W-1:0] {
    B_NOP, B_SUB, B_OR, B_AND, B_READ, B_AC2DR, B_INCDR, B_PC2DR
  } fb_e;

  typedef enum logic [FLD_W-1:0] {
    C_NOP, C_XOR, C_NOT, C_SHL, C_SHR, C_INCPC, C_AR2PC, C_RSVD
  } fc_e;

  typedef struct packed {
    logic [FLD_W-1:0] fa;
    logic [FLD_W-1:0] fb;
    logic [FLD_W-1:0] fc;
    logic [CD_W-1:0]  cd;
    logic [BR_W-1:0]  br;
    logic [AD_W-1:0]  ad;
  } uop_t;
endpackage

// File: rtl/uop_field_dec.sv
module uop_field_dec #(
  parameter int W = 3
) (
  input  logic              en,
  input  logic [W-1:0]      code,
  output logic [(1<<W)-1:0] hot
);
  localparam int N = 1 << W;

  always_comb begin
    hot = '0;
    for (int i = 0; i < N; i++) begin
      if (en && (code == i[W-1:0])) hot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/uop_ac_chain.sv
module uop_ac_chain
  import uop_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]    ac,
  input  logic [DW-1:0]    dr,
  input  logic [NCODE-1:0] ha,
  input  logic [NCODE-1:0] hb,
  input  logic [NCODE-1:0] hc,
  output logic [DW-1:0]    ac_next
);
  logic [DW-1:0] s_a, s_b;
  logic          unused_codes;

  assign unused_codes = ^{ha[0], ha[7:5], hb[0], hb[7:4], hc[0], hc[7:5]};

  always_comb begin
    s_a = ac;
    if (ha[A_ADD])        s_a = ac + dr;
    else if (ha[A_CLR])   s_a = '0;
    else if (ha[A_INC])   s_a = ac + 1'b1;
    else if (ha[A_DR2AC]) s_a = dr;
  end

  always_comb begin
    s_b = s_a;
    if (hb[B_SUB])        s_b = s_a - dr;
    else if (hb[B_OR])    s_b = s_a | dr;
    else if (hb[B_AND])   s_b = s_a & dr;
  end

  always_comb begin
    ac_next = s_b;
    if (hc[C_XOR])        ac_next = s_b ^ dr;
    else if (hc[C_NOT])   ac_next = ~s_b;
    else if (hc[C_SHL])   ac_next = {s_b[DW-2:0], 1'b0};
    else if (hc[C_SHR])   ac_next = {1'b0, s_b[DW-1:1]};
  end
endmodule

// File: rtl/uop_mem.sv
module uop_mem #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pl_en,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  assign rd_data = store[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (pl_en) store[pl_addr] <= pl_data;
  end
endmodule

// File: rtl/uop_exec.sv
module uop_exec
  import uop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       uop_valid,
  output logic                       uop_ready,
  input  logic [UOP_W-1:0]           uop_word,
  input  logic                       pre_we,
  input  logic [ADDR_W-1:0]          pre_addr,
  input  logic [DATA_W-1:0]          pre_data,
  output logic [CD_W-1:0]            cd_out,
  output logic [BR_W-1:0]            br_out,
  output logic [AD_W-1:0]            ad_out,
  output logic                       ac_sign,
  output logic                       ac_zero,
  output logic                       dr_ind,
  output logic [DATA_W-ADDR_W-2:0]   dr_opc,
  output logic [DATA_W-1:0]          ac_out,
  output logic [DATA_W-1:0]          dr_out,
  output logic [ADDR_W-1:0]          ar_out,
  output logic [ADDR_W-1:0]          pc_out
);
  localparam int NFLD = 3;

  uop_t              uw;
  logic [FLD_W-1:0]  fld [NFLD];
  logic [NCODE-1:0]  hot [NFLD];
  logic              run;

  logic [DATA_W-1:0] ac_q, dr_q, ac_nx, mem_rd;
  logic [ADDR_W-1:0] ar_q, pc_q, ar_d;
  logic              ar_ld;

  assign uw        = uop_word;
  assign uop_ready = 1'b1;
  assign run       = uop_valid && !rst;
  assign fld[0]    = uw.fa;
  assign fld[1]    = uw.fb;
  assign fld[2]    = uw.fc;

  generate
    for (genvar g = 0; g < NFLD; g++) begin : g_dec
      uop_field_dec #(.W(FLD_W)) u_dec (
        .en   (run),
        .code (fld[g]),
        .hot  (hot[g])
      );
    end
  endgenerate

  uop_ac_chain #(.DW(DATA_W)) u_chain (
    .ac      (ac_q),
    .dr      (dr_q),
    .ha      (hot[0]),
    .hb      (hot[1]),
    .hc      (hot[2]),
    .ac_next (ac_nx)
  );

  uop_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk     (clk),
    .rd_addr (ar_q),
    .rd_data (mem_rd),
    .wr_en   (hot[0][A_WRITE]),
    .wr_addr (ar_q),
    .wr_data (dr_q),
    .pl_en   (pre_we),
    .pl_addr (pre_addr),
    .pl_data (pre_data)
  );

  assign ar_ld = hot[0][A_DR2AR] | hot[0][A_PC2AR];
  assign ar_d  = hot[0][A_DR2AR] ? dr_q[ADDR_W-1:0] : pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q <= '0;
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      ac_q <= ac_nx;
      if (hot[1][B_READ])       dr_q <= mem_rd;
      else if (hot[1][B_AC2DR]) dr_q <= ac_q;
      else if (hot[1][B_INCDR]) dr_q <= dr_q + 1'b1;
      else if (hot[1][B_PC2DR]) dr_q[ADDR_W-1:0] <= pc_q;
      if (ar_ld) ar_q <= ar_d;
      if (hot[2][C_INCPC])      pc_q <= pc_q + 1'b1;
      else if (hot[2][C_AR2PC]) pc_q <= ar_q;
    end
  end

  assign cd_out  = uw.cd;
  assign br_out  = uw.br;
  assign ad_out  = uw.ad;
  assign ac_sign = ac_q[DATA_W-1];
  assign ac_zero = (ac_q == '0);
  assign dr_ind  = dr_q[DATA_W-1];
  assign dr_opc  = dr_q[DATA_W-2:ADDR_W];
  assign ac_out  = ac_q;
  assign dr_out  = dr_q;
  assign ar_out  = ar_q;
  assign pc_out  = pc_q;

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !uop_valid |=> ($stable(ac_q) && $stable(dr_q) && $stable(ar_q) && $stable(pc_q)));

  p_ar_from_dr_r5: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_word[FA_LSB +: FLD_W] == 3'b101) |=> (ar_q == $past(dr_q[ADDR_W-1:0])));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_word[FC_LSB +: FLD_W] == 3'b101) |=> (pc_q == $past(pc_q) + 1'b1));

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_word[FC_LSB +: FLD_W] != 3'b101 && uop_word[FC_LSB +: FLD_W] != 3'b110)
      |=> $stable(pc_q));

  p_dr_from_ac_r9: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_word[FB_LSB +: FLD_W] == 3'b101) |=> (dr_q == $past(ac_q)));
endmodule

// File: tb/sim_uop_exec.sv
module sim_uop_exec;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        uop_valid = 1'b0;
  logic        uop_ready;
  logic [19:0] uop_word = '0;
  logic        pre_we = 1'b0;
  logic [10:0] pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic [1:0]  cd_out, br_out;
  logic [6:0]  ad_out;
  logic        ac_sign, ac_zero, dr_ind;
  logic [3:0]  dr_opc;
  logic [15:0] ac_out, dr_out;
  logic [10:0] ar_out, pc_out;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_ac = '0, m_dr = '0;
  logic [10:0] m_ar = '0, m_pc = '0;
  logic [15:0] m_mem [2048];

  always #(CLK_P/2) clk = ~clk;

  uop_exec u0 (
    .clk(clk), .rst(rst), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_word(uop_word), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .cd_out(cd_out), .br_out(br_out), .ad_out(ad_out),
    .ac_sign(ac_sign), .ac_zero(ac_zero), .dr_ind(dr_ind), .dr_opc(dr_opc),
    .ac_out(ac_out), .dr_out(dr_out), .ar_out(ar_out), .pc_out(pc_out)
  );

  function automatic logic [19:0] mk(int a, int b, int c, int rest);
    return {a[2:0], b[2:0], c[2:0], rest[10:0]};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(bit r, bit v, logic [19:0] w, bit pw,
                            logic [10:0] pa, logic [15:0] pd);
    logic [15:0] oac, odr, a;
    logic [10:0] oar, opc;
    logic [2:0]  fa, fb, fc;
    oac = m_ac; odr = m_dr; oar = m_ar; opc = m_pc;
    fa = w[19:17]; fb = w[16:14]; fc = w[13:11];
    if (r) begin
      m_ac = '0; m_dr = '0; m_ar = '0; m_pc = '0;
    end else if (v) begin
      a = oac;
      case (fa)
        3'd1: a = a + odr;
        3'd2: a = '0;
        3'd3: a = a + 16'd1;
        3'd4: a = odr;
        default: ;
      endcase
      case (fb)
        3'd1: a = a - odr;
        3'd2: a = a | odr;
        3'd3: a = a & odr;
        default: ;
      endcase
      case (fc)
        3'd1: a = a ^ odr;
        3'd2: a = ~a;
        3'd3: a = a << 1;
        3'd4: a = a >> 1;
        default: ;
      endcase
      m_ac = a;
      case (fb)
        3'd4: m_dr = m_mem[oar];
        3'd5: m_dr = oac;
        3'd6: m_dr = odr + 16'd1;
        3'd7: m_dr = {odr[15:11], opc};
        default: ;
      endcase
      if (fa == 3'd5) m_ar = odr[10:0];
      if (fa == 3'd6) m_ar = opc;
      if (fc == 3'd5) m_pc = opc + 11'd1;
      if (fc == 3'd6) m_pc = oar;
      if (fa == 3'd7) m_mem[oar] = odr;
    end
    if (pw) m_mem[pa] = pd;
  endtask

  task automatic step(bit r, bit v, logic [19:0] w, bit pw,
                      logic [10:0] pa, logic [15:0] pd, string ctx);
    rst = r; uop_valid = v; uop_word = w;
    pre_we = pw; pre_addr = pa; pre_data = pd;
    #1;
    chk({"R1 ", ctx}, "cd_out", int'(cd_out), int'(w[10:9]));
    chk({"R1 ", ctx}, "br_out", int'(br_out), int'(w[8:7]));
    chk({"R1 ", ctx}, "ad_out", int'(ad_out), int'(w[6:0]));
    chk({"R3 ", ctx}, "uop_ready", int'(uop_ready), 1);
    @(posedge clk);
    model_edge(r, v, w, pw, pa, pd);
    @(negedge clk);
    chk({"R4 R7 R8 ", ctx}, "ac", int'(ac_out), int'(m_ac));
    chk({"R6 R9 R12 ", ctx}, "dr", int'(dr_out), int'(m_dr));
    chk({"R5 ", ctx}, "ar", int'(ar_out), int'(m_ar));
    chk({"R10 ", ctx}, "pc", int'(pc_out), int'(m_pc));
    chk({"R11 ", ctx}, "ac_sign", int'(ac_sign), int'(m_ac[15]));
    chk({"R11 ", ctx}, "ac_zero", int'(ac_zero), int'(m_ac == 16'd0));
    chk({"R11 ", ctx}, "dr_ind", int'(dr_ind), int'(m_dr[15]));
    chk({"R11 ", ctx}, "dr_opc", int'(dr_opc), int'(m_dr[14:11]));
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    @(negedge clk);
    // R2: reset state
    step(1'b1, 1'b1, mk(1, 2, 3, 0), 1'b0, '0, '0, "R2 reset");
    step(1'b1, 1'b0, '0, 1'b0, '0, '0, "R2 reset");
    // R12: fill memory through the preload port
    for (int i = 0; i < 2048; i++) begin
      rv = 32'(i) * 32'd40503 ^ 32'h5a5a;
      step(1'b0, 1'b0, mk(0, 0, 0, i), 1'b1, i[10:0], rv[15:0], "R12 preload");
    end
    // R6: read word 0 into DR (AR is 0)
    step(1'b0, 1'b1, mk(0, 4, 0, 0), 1'b0, '0, '0, "R6 read");
    // R12: preload beats a uop write to the same word
    step(1'b0, 1'b1, mk(7, 0, 0, 0), 1'b1, 11'd0, 16'hBEEF, "R12 conflict");
    step(1'b0, 1'b1, mk(0, 4, 0, 0), 1'b0, '0, '0, "R12 readback");
    // R6: read before write on the same word
    step(1'b0, 1'b1, mk(0, 6, 0, 0), 1'b0, '0, '0, "R9 incdr");
    step(1'b0, 1'b1, mk(7, 4, 0, 0), 1'b0, '0, '0, "R6 rw same word");
    step(1'b0, 1'b1, mk(0, 4, 0, 0), 1'b0, '0, '0, "R6 readback");
    // R8: clear then subtract gives 0 - DR
    step(1'b0, 1'b1, mk(2, 1, 0, 0), 1'b0, '0, '0, "R8 clr-sub");
    step(1'b0, 1'b1, mk(3, 2, 3, 0), 1'b0, '0, '0, "R8 chain");
    // R10: reserved field C code is a no-op
    step(1'b0, 1'b1, mk(0, 0, 7, 0), 1'b0, '0, '0, "R10 reserved");
    // R3: idle and all-zero words
    step(1'b0, 1'b0, mk(1, 1, 1, 1234), 1'b0, '0, '0, "R3 not valid");
    step(1'b0, 1'b1, mk(0, 0, 0, 999), 1'b0, '0, '0, "R3 all nop");
    // R5: AR loads
    step(1'b0, 1'b1, mk(5, 0, 5, 0), 1'b0, '0, '0, "R5 dr2ar");
    step(1'b0, 1'b1, mk(6, 7, 6, 0), 1'b0, '0, '0, "R5 pc2ar");
    // random mixes, occasional reset and preload
    for (int n = 0; n < 3000; n++) begin
      rv = $urandom;
      step(rv[31:26] == 6'd0, rv[25:23] != 3'd0, rv[19:0], rv[22:21] == 2'b11,
           rv[10:0] ^ 11'h2a5, rv[31:16], "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule